// File: doc/BRIEF.md
# Destination Chain DMA Tag Engine

This block drains 32-bit words from an intermediate FIFO and stores them to memory as 128-bit quadwords. It is the receiving end of a transfer that has already been placed in the FIFO by some other agent. Software starts it with a single control write. That write carries the mode (normal or chain), a tag-interrupt enable, an initial quadword count and an initial destination address. The engine then runs until the transfer ends, and it signals the end with a one-cycle done pulse.

In normal mode the engine moves exactly the programmed number of quadwords. In chain mode the data stream itself carries destination tags. Each tag is one quadword whose first word gives a count, a tag ID and an interrupt flag, and whose second word gives the destination address. The tag is followed by that many data quadwords. Data moves in bursts sized by what the FIFO currently holds, so one packet may arrive in several pieces. When the engine is the configured stall source, it also maintains a stall-address output that a neighbouring channel compares against.

Top module: `dchain_dma`

## Requirements
- R1: After reset, busy, done, fifo_rd and mem_we are 0 and stall_addr is 0.
- R2: A control write with start=1 loads mode, tag-interrupt enable, count and address (the address is forced to a multiple of 16), clears the end flag and raises busy. A control write with start=0 stops the engine at once: busy falls and no done pulse follows.
- R3: A tag is consumed only when fifo_count is at least 4. It is popped as four words. In word0, bits [15:0] are the count, bits [30:28] are the ID and bit 31 is the IRQ flag. Word1 is the destination address, with bits [3:0] ignored. Words 2 and 3 are discarded.
- R4: Each data quadword is four consecutive FIFO words, with word k placed at mem_data[32k+31:32k]. It is written at the current address, and the address then advances by 16.
- R5: A data burst starts only when fifo_count is at least 4. It moves min(remaining count, fifo_count/4) quadwords and then re-evaluates, so a packet may be split across several bursts.
- R6: ID 7 (END) makes the current packet the last one. ID 1 (CNT) and any ID other than 0 and 7 only continue the chain.
- R7: A tag with IRQ=1 ends the transfer after its packet when tag-interrupt enable is set. Without the enable, the IRQ flag has no effect.
- R8: A tag with ID 0 (CNTS) copies its aligned address into stall_addr when stall_src is 1. When stall_src is 0, stall_addr does not change.
- R9: When a data write brings the count to zero and stall_src is 1, stall_addr takes the following address, but only in normal mode or when the active tag is CNTS.
- R10: With the count at zero, the transfer ends when the engine is in normal mode or the end flag is set. Ending means done is high for exactly one cycle and busy falls in that same cycle. Otherwise the engine reads the next tag.
- R11: fifo_rd is asserted only while busy and only when fifo_count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_start | input | 1 | Start (1) or stop (0) on a control write |
| ctl_chain | input | 1 | 1 selects chain mode, 0 normal mode |
| ctl_tie | input | 1 | Tag-interrupt enable |
| ctl_qwc | input | QWC_W | Initial quadword count |
| ctl_addr | input | ADDR_W | Initial destination address |
| stall_src | input | 1 | This channel is the configured stall source |
| fifo_count | input | CNT_W | Words currently held in the FIFO |
| fifo_data | input | 32 | Head word of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pops the head word at the clock edge |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | 128 | Memory write quadword |
| stall_addr | output | ADDR_W | Stall-address register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume a well-behaved FIFO on the input side. fifo_count may fall only through the engine's own pops, and fifo_data always presents the current head word. Under that assumption, a pop is never issued against an empty FIFO. The bench models the FIFO as a queue: it only appends words between edges and removes one word at each edge where fifo_rd is high. Control writes are issued only while the engine is idle, or while it is waiting on the FIFO and not in the middle of consuming a quadword.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam logic [2:0] TID_CNTS = 3'd0;
  localparam logic [2:0] TID_CNT  = 3'd1;
  localparam logic [2:0] TID_END  = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_TAG,
    ST_DATA
  } dstate_t;
endpackage

// File: rtl/dchain_rst_sync.sv
module dchain_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dchain_tag_dec.sv
module dchain_tag_dec #(
  parameter int QWC_W = 16
) (
  input  logic [31:0]      word0,
  output logic [QWC_W-1:0] tag_qwc,
  output logic [2:0]       tag_id,
  output logic             tag_irq
);
  assign tag_qwc = word0[QWC_W-1:0];
  assign tag_id  = word0[30:28];
  assign tag_irq = word0[31];
endmodule

// File: rtl/dchain_burst.sv
module dchain_burst #(
  parameter int QWC_W = 16,
  parameter int CNT_W = 8
) (
  input  logic [QWC_W-1:0] remain,
  input  logic [CNT_W-1:0] fifo_count,
  output logic [QWC_W-1:0] burst_len
);
  localparam int W = (QWC_W > CNT_W) ? QWC_W : CNT_W;

  logic [W-1:0] avail_qw;
  logic [W-1:0] remain_w;

  assign avail_qw  = W'(fifo_count >> 2);
  assign remain_w  = W'(remain);
  assign burst_len = (remain_w < avail_qw) ? remain : QWC_W'(avail_qw);
endmodule

// File: rtl/dchain_qw_pack.sv
module dchain_qw_pack (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         take,
  input  logic [31:0]  word,
  output logic         qw_valid,
  output logic [127:0] qw
);
  localparam int LANES = 4;

  logic [1:0]  idx_q, idx_d;
  logic [31:0] held_q [LANES-1];

  always_comb begin
    idx_d = idx_q;
    if (clr)       idx_d = 2'd0;
    else if (take) idx_d = idx_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= 2'd0;
    else        idx_q <= idx_d;
  end

  for (genvar k = 0; k < LANES - 1; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                held_q[k] <= 32'd0;
      else if (take && !clr && idx_q == 2'(k))   held_q[k] <= word;
    end
  end

  assign qw_valid = take && !clr && (idx_q == 2'd3);
  assign qw       = {word, held_q[2], held_q[1], held_q[0]};
endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
  import dchain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_start,
  input  logic              ctl_chain,
  input  logic              ctl_tie,
  input  logic [QWC_W-1:0]  ctl_qwc,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic              stall_src,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic [31:0]       fifo_data,
  output logic              fifo_rd,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [127:0]      mem_data,
  output logic [ADDR_W-1:0] stall_addr,
  output logic              busy,
  output logic              done
);
  localparam logic [ADDR_W-1:0] QW_BYTES = ADDR_W'(16);
  localparam logic [CNT_W-1:0]  MIN_WORDS = CNT_W'(4);

  function automatic logic [ADDR_W-1:0] qw_align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:4], 4'b0000};
  endfunction

  logic rst_i_n;

  dstate_t           st_q, st_d;
  logic [QWC_W-1:0]  qwc_q, qwc_d;
  logic [QWC_W-1:0]  burst_q, burst_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] stall_q, stall_d;
  logic [2:0]        tid_q, tid_d;
  logic              end_q, end_d;
  logic              chain_q, chain_d;
  logic              tie_q, tie_d;
  logic              done_q, done_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] maddr_q;
  logic [127:0]      mdata_q;

  logic              pk_clr;
  logic              qw_valid;
  logic [127:0]      qw;
  logic [QWC_W-1:0]  tg_qwc;
  logic [2:0]        tg_id;
  logic              tg_irq;
  logic [QWC_W-1:0]  burst_len;
  logic              have_qw;
  logic [ADDR_W-1:0] tg_addr;
  logic [ADDR_W-1:0] addr_next;

  dchain_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  dchain_qw_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (pk_clr),
    .take     (fifo_rd),
    .word     (fifo_data),
    .qw_valid (qw_valid),
    .qw       (qw)
  );

  dchain_tag_dec #(.QWC_W(QWC_W)) u_tag (
    .word0   (qw[31:0]),
    .tag_qwc (tg_qwc),
    .tag_id  (tg_id),
    .tag_irq (tg_irq)
  );

  dchain_burst #(.QWC_W(QWC_W), .CNT_W(CNT_W)) u_burst (
    .remain     (qwc_q),
    .fifo_count (fifo_count),
    .burst_len  (burst_len)
  );

  assign have_qw   = (fifo_count >= MIN_WORDS);
  assign tg_addr   = qw_align(qw[32 +: ADDR_W]);
  assign addr_next = addr_q + QW_BYTES;
  assign fifo_rd   = (st_q == ST_TAG) || (st_q == ST_DATA);

  // next-state logic
  always_comb begin
    st_d    = st_q;
    qwc_d   = qwc_q;
    burst_d = burst_q;
    addr_d  = addr_q;
    stall_d = stall_q;
    tid_d   = tid_q;
    end_d   = end_q;
    chain_d = chain_q;
    tie_d   = tie_q;
    done_d  = 1'b0;
    we_d    = 1'b0;
    pk_clr  = 1'b0;

    unique case (st_q)
      ST_EVAL: begin
        if (qwc_q == '0) begin
          if (!chain_q || end_q) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else if (have_qw) begin
            st_d = ST_TAG;
          end
        end else if (have_qw) begin
          st_d    = ST_DATA;
          burst_d = burst_len;
        end
      end
      ST_TAG: begin
        if (qw_valid) begin
          qwc_d  = tg_qwc;
          addr_d = tg_addr;
          tid_d  = tg_id;
          if (tg_id == TID_END || (tie_q && tg_irq)) end_d = 1'b1;
          if (tg_id == TID_CNTS && stall_src)        stall_d = tg_addr;
          st_d = ST_EVAL;
        end
      end
      ST_DATA: begin
        if (qw_valid) begin
          we_d    = 1'b1;
          addr_d  = addr_next;
          qwc_d   = qwc_q - 1'b1;
          burst_d = burst_q - 1'b1;
          if (qwc_q == QWC_W'(1) && stall_src && (!chain_q || tid_q == TID_CNTS))
            stall_d = addr_next;
          if (burst_q == QWC_W'(1)) st_d = ST_EVAL;
        end
      end
      default: ;
    endcase

    // a control write takes priority over everything else
    if (ctl_wr) begin
      pk_clr = 1'b1;
      done_d = 1'b0;
      end_d  = 1'b0;
      if (ctl_start) begin
        st_d    = ST_EVAL;
        chain_d = ctl_chain;
        tie_d   = ctl_tie;
        qwc_d   = ctl_qwc;
        addr_d  = qw_align(ctl_addr);
        tid_d   = TID_CNT;
      end else begin
        st_d = ST_IDLE;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      qwc_q   <= '0;
      burst_q <= '0;
      addr_q  <= '0;
      stall_q <= '0;
      tid_q   <= TID_CNT;
      end_q   <= 1'b0;
      chain_q <= 1'b0;
      tie_q   <= 1'b0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      qwc_q   <= qwc_d;
      burst_q <= burst_d;
      addr_q  <= addr_d;
      stall_q <= stall_d;
      tid_q   <= tid_d;
      end_q   <= end_d;
      chain_q <= chain_d;
      tie_q   <= tie_d;
      done_q  <= done_d;
      we_q    <= we_d;
    end
  end

  // memory write payload, enabled only on a completed quadword
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      maddr_q <= '0;
      mdata_q <= '0;
    end else if (we_d) begin
      maddr_q <= addr_q;
      mdata_q <= qw;
    end
  end

  assign mem_we     = we_q;
  assign mem_addr   = maddr_q;
  assign mem_data   = mdata_q;
  assign stall_addr = stall_q;
  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
endmodule

// File: rtl/dchain_dma_chk.sv
module dchain_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic              ctl_start,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              fifo_rd,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done
);
  // R11: never pop an empty FIFO
  a_r11_rd_has_word: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (fifo_count != '0));

  // R11: pops only while a transfer runs
  a_r11_rd_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> busy);

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: busy has fallen when done is seen
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: a stop write never produces a done pulse
  a_r2_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_start) |=> (!done && !busy));

  // R4: writes land on quadword boundaries
  a_r4_write_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[3:0] == 4'd0));
endmodule

bind dchain_dma dchain_dma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_start  (ctl_start),
  .fifo_count (fifo_count),
  .fifo_rd    (fifo_rd),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .busy       (busy),
  .done       (done)
);

// File: tb/sim_dchain_dma.sv
module sim_dchain_dma;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int QWC_W  = 16;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctl_wr = 1'b0, ctl_start = 1'b0, ctl_chain = 1'b0, ctl_tie = 1'b0;
  logic [QWC_W-1:0]  ctl_qwc = '0;
  logic [ADDR_W-1:0] ctl_addr = '0;
  logic              stall_src = 1'b0;
  logic [CNT_W-1:0]  fifo_count = '0;
  logic [31:0]       fifo_data = '0;
  logic              fifo_rd, mem_we, busy, done;
  logic [ADDR_W-1:0] mem_addr, stall_addr;
  logic [127:0]      mem_data;

  int total = 0, bad = 0, done_seen = 0, cyc = 0;
  bit finished = 0;
  logic [31:0]       fq[$];
  logic [ADDR_W-1:0] exp_a[$];
  logic [127:0]      exp_d[$];

  always #(CLK_P/2) clk = ~clk;

  dchain_dma #(.ADDR_W(ADDR_W), .QWC_W(QWC_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_start(ctl_start),
    .ctl_chain(ctl_chain), .ctl_tie(ctl_tie), .ctl_qwc(ctl_qwc), .ctl_addr(ctl_addr),
    .stall_src(stall_src), .fifo_count(fifo_count), .fifo_data(fifo_data),
    .fifo_rd(fifo_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .stall_addr(stall_addr), .busy(busy), .done(done));

  function automatic void chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, expv);
    end
  endfunction

  function automatic void refresh();
    fifo_count = CNT_W'(fq.size());
    fifo_data  = (fq.size() > 0) ? fq[0] : 32'd0;
  endfunction

  // FIFO model: pops at the edge, presents the new head shortly after
  always @(posedge clk) begin
    if (fifo_rd && fq.size() > 0) void'(fq.pop_front());
    #1 refresh();
  end

  // reference comparison every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (exp_a.size() == 0) chk(0, "R4 unexpected write", 128'(mem_addr), 0);
        else begin
          logic [ADDR_W-1:0] ea;
          logic [127:0] ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk(mem_addr == ea, "R4 write address", 128'(mem_addr), 128'(ea));
          chk(mem_data == ed, "R4 write data", mem_data, ed);
        end
      end
      if (fifo_rd) chk(fifo_count != 0, "R11 pop of empty FIFO", 128'(fifo_count), 1);
      if (done) begin
        done_seen++;
        chk(!busy, "R10 busy low with done", 128'(busy), 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic push(input logic [31:0] w);
    fq.push_back(w);
    refresh();
  endtask

  task automatic send_qw(input logic [ADDR_W-1:0] a, input logic [31:0] seed);
    logic [127:0] d;
    for (int j = 0; j < 4; j++) d[32*j +: 32] = seed + 32'(j);
    exp_a.push_back(a);
    exp_d.push_back(d);
    for (int j = 0; j < 4; j++) push(seed + 32'(j));
  endtask

  task automatic send_tag(input logic [31:0] w0, input logic [31:0] a);
    push(w0);
    push(a);
    push(32'hBEEF_0002);
    push(32'hBEEF_0003);
  endtask

  task automatic ctl(input bit start, input bit chain, input bit tie,
                     input logic [QWC_W-1:0] n, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    ctl_wr = 1; ctl_start = start; ctl_chain = chain; ctl_tie = tie; ctl_qwc = n; ctl_addr = a;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic wait_done(input string rq);
    int base;
    base = done_seen;
    for (int i = 0; i < 400 && done_seen == base; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_seen == base + 1, rq, 128'(done_seen - base), 1);
    chk(exp_a.size() == 0, {rq, " all writes"}, 128'(exp_a.size()), 0);
    chk(!busy, {rq, " busy low"}, 128'(busy), 0);
  endtask

  initial begin
    refresh();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !fifo_rd && !mem_we, "R1 reset outputs", {busy, done, fifo_rd, mem_we}, 0);
    chk(stall_addr == 0, "R1 reset stall_addr", 128'(stall_addr), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R1 after release", {busy, done}, 0);

    // R10: normal mode with zero count ends at once, no pop
    stall_src = 1;
    ctl(1, 0, 0, 0, 32'h0);
    wait_done("R10 normal zero count");

    // R2/R9: normal mode, unaligned start address, stall update
    ctl(1, 0, 0, 2, 32'h1008);
    chk(busy, "R2 busy after start", 128'(busy), 1);
    send_qw(32'h1000, 32'h1100_0000);
    send_qw(32'h1010, 32'h1200_0000);
    wait_done("R10 normal end");
    chk(stall_addr == 32'h1020, "R9 normal-mode stall update", 128'(stall_addr), 32'h1020);

    // R3/R6/R7: chain, IRQ without enable, unknown ID, END
    ctl(1, 1, 0, 0, 32'h0);
    send_tag(32'h9000_0002, 32'h200C);
    send_qw(32'h2000, 32'h2100_0000);
    send_qw(32'h2010, 32'h2200_0000);
    repeat (20) @(negedge clk);
    chk(busy, "R7 IRQ ignored without enable", 128'(busy), 1);
    send_tag(32'h3000_0001, 32'h2100);
    send_qw(32'h2100, 32'h2300_0000);
    repeat (15) @(negedge clk);
    chk(busy, "R6 other ID continues", 128'(busy), 1);
    send_tag(32'h7000_0001, 32'h2200);
    send_qw(32'h2200, 32'h2400_0000);
    wait_done("R6 END tag ends");
    chk(stall_addr == 32'h1020, "R9 no update for non-CNTS chain", 128'(stall_addr), 32'h1020);

    // R8/R9/R7: CNTS with stall source, IRQ with enable
    ctl(1, 1, 1, 0, 32'h0);
    send_tag(32'h0000_0001, 32'h4000);
    repeat (12) @(negedge clk);
    chk(stall_addr == 32'h4000, "R8 CNTS copies address", 128'(stall_addr), 32'h4000);
    send_qw(32'h4000, 32'h4100_0000);
    repeat (12) @(negedge clk);
    chk(stall_addr == 32'h4010, "R9 CNTS count-zero update", 128'(stall_addr), 32'h4010);
    send_tag(32'h9000_0002, 32'h4100);
    send_qw(32'h4100, 32'h4200_0000);
    send_qw(32'h4110, 32'h4300_0000);
    wait_done("R7 IRQ with enable ends");
    chk(stall_addr == 32'h4010, "R9 CNT packet leaves stall", 128'(stall_addr), 32'h4010);

    // R8: CNTS without stall source
    stall_src = 0;
    ctl(1, 1, 0, 0, 32'h0);
    send_tag(32'h0000_0001, 32'h5000);
    send_qw(32'h5000, 32'h5100_0000);
    send_tag(32'h7000_0000, 32'h5100);
    wait_done("R8 END with zero count");
    chk(stall_addr == 32'h4010, "R8 no stall change when not source", 128'(stall_addr), 32'h4010);

    // R3/R5: partial tag held back, packet split across bursts
    ctl(1, 1, 0, 0, 32'h0);
    push(32'h1000_0003); push(32'h6000); push(32'hBEEF_0002);
    repeat (10) @(negedge clk);
    chk(fifo_count == 3, "R3 tag waits for four words", 128'(fifo_count), 3);
    push(32'hBEEF_0003);
    send_qw(32'h6000, 32'h6100_0000);
    send_qw(32'h6010, 32'h6200_0000);
    repeat (30) @(negedge clk);
    chk(exp_a.size() == 0 && busy, "R5 first burst of two", 128'(exp_a.size()), 0);
    send_qw(32'h6020, 32'h6300_0000);
    send_tag(32'h7000_0000, 32'h6100);
    wait_done("R5 split packet completes");

    // R2: stop while waiting, then stop mid-quadword and restart cleanly
    ctl(1, 1, 0, 0, 32'h0);
    repeat (5) @(negedge clk);
    begin
      int base;
      base = done_seen;
      ctl(0, 0, 0, 0, 32'h0);
      repeat (10) @(negedge clk);
      chk(!busy && done_seen == base, "R2 stop without done", {busy, 32'(done_seen - base)}, 0);
    end
    ctl(1, 1, 0, 0, 32'h0);
    send_tag(32'h1000_0002, 32'h7000);
    send_qw(32'h7000, 32'h7100_0000);
    push(32'hAAAA_0000);
    repeat (20) @(negedge clk);
    ctl(0, 0, 0, 0, 32'h0);
    fq.delete();
    refresh();
    ctl(1, 0, 0, 1, 32'h710C);
    send_qw(32'h7100, 32'h7200_0000);
    wait_done("R2 restart after stop");

    // R2: chain start with non-zero count moves data before the first tag
    ctl(1, 1, 0, 1, 32'h8000);
    send_qw(32'h8000, 32'h8100_0000);
    send_tag(32'h7000_0000, 32'h8100);
    wait_done("R2 chain with preset count");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule